// File: doc/BRIEF.md
# Channel FIFO Depth Controller

This block keeps the FIFO configuration state of one serial channel and the byte queue whose usable size follows from it. Software writes three small control registers through a plain write strobe with address and data. A board-level depth-select input joins them. A priority decode turns these inputs into an operating mode and an effective depth of 1, 16 or 128 entries. A 128-entry storage queue with push and pop ports uses that depth for its full flag.

The enable bit in the FIFO control register is the gate. While it is clear, the queue holds one byte and nothing else matters. Once it is set, the enhanced-feature bit, the depth-select input and a guarded extension bit choose between 16 and 128 entries, in that order of priority. The extension bit can only be changed while the guard bit of the line control register is set. Whenever the effective depth changes, both queue pointers are cleared, so the queue starts empty in its new size.

Register map used throughout: address 0 is FIFO control (bit 0 enable, bit 5 depth extension), address 1 is line control (bit 7 guard), address 2 is enhanced features (bit 4 enhanced mode). Mode codes are 0 byte, 1 sixteen-deep, 2 deep by pin, 3 extended, 4 enhanced.

Top module: `chanfifo_ctrl`

## Requirements
- R1: After reset, mode is 0, depth is 1, the queue is empty and not full, and the line control and enhanced-feature registers read 0.
- R2: While FIFO control bit 0 is 0, mode is 0 and depth is 1 whatever the pin, FIFO control bit 5 and enhanced bit 4 hold; one push makes the queue full.
- R3: With enable set, pin `deep_sel_n` high, extension bit 0 and enhanced bit 0, mode is 1 and depth is 16.
- R4: With enable set, pin low and enhanced bit 0, mode is 2 and depth is 128.
- R5: A FIFO control write changes bit 5 only while line control bit 7 is 1; bit 0 is written in every case.
- R6: With enable set, pin high, extension bit 1 and enhanced bit 0, mode is 3 and depth is 128.
- R7: With enable set and enhanced bit 1, mode is 4 and depth is 128 whatever the pin and extension bit hold.
- R8: The full flag is set when the occupancy equals the effective depth; a push while full is dropped and `overflow` is high for exactly the following cycle; a pop while empty is ignored.
- R9: Bytes leave in the order they entered; a push and a pop in the same cycle both take effect when the queue is neither full nor empty, leaving the occupancy unchanged.
- R10: A change of effective depth empties the queue at the next clock edge; push and pop in that cycle are discarded.
- R11: Reads return the stored line control and enhanced-feature values; address 0 and address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (write and read) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| deep_sel_n | input | 1 | Depth select: high gives 16 entries, low gives 128 |
| push | input | 1 | Push request |
| push_data | input | 8 | Byte to push |
| pop | input | 1 | Pop request |
| pop_data | output | 8 | Byte at the head of the queue |
| full | output | 1 | Occupancy equals effective depth |
| empty | output | 1 | Queue holds no bytes |
| overflow | output | 1 | One-cycle pulse after a dropped push |
| count | output | 8 | Current occupancy |
| mode | output | 3 | Operating mode code |
| depth | output | 8 | Effective depth |

## Verification
The two functions that can fall in one cycle are a push and a pop, and the bench presents them together on a partly filled queue, on a full queue and on an empty one. On the partly filled queue both must act, so the occupancy stays the same and the head byte advances. On the full queue the pop is taken, the push is dropped and `overflow` pulses. On the empty queue only the push is taken. Each case is judged from `count`, `pop_data` and `overflow` one cycle later.

// File: rtl/chanfifo_pkg.sv
package chanfifo_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 2;
    localparam int STORE_DEPTH = 128;
    localparam int SHALLOW     = 16;
    localparam int PTR_W       = $clog2(STORE_DEPTH);
    localparam int CNT_W       = PTR_W + 1;

    localparam logic [ADDR_W-1:0] A_FCR = 2'd0;
    localparam logic [ADDR_W-1:0] A_LCR = 2'd1;
    localparam logic [ADDR_W-1:0] A_EFR = 2'd2;

    localparam int FCR_EN_BIT  = 0;
    localparam int FCR_EXT_BIT = 5;
    localparam int LCR_GRD_BIT = 7;
    localparam int EFR_ENH_BIT = 4;

    typedef enum logic [2:0] {
        MODE_BYTE = 3'd0,
        MODE_D16  = 3'd1,
        MODE_PIN  = 3'd2,
        MODE_EXT  = 3'd3,
        MODE_ENH  = 3'd4
    } fifo_mode_e;

    typedef struct packed {
        logic enable;
        logic ext;
        logic guard;
        logic enh;
    } mode_bits_t;

    function automatic logic [CNT_W-1:0] depth_of(fifo_mode_e m);
        case (m)
            MODE_BYTE: depth_of = CNT_W'(1);
            MODE_D16:  depth_of = CNT_W'(SHALLOW);
            default:   depth_of = CNT_W'(STORE_DEPTH);
        endcase
    endfunction

endpackage

// File: rtl/chanfifo_regs.sv
module chanfifo_regs
    import chanfifo_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output mode_bits_t    bits
);

    logic [DW-1:0] fcr_q, lcr_q, efr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fcr_q <= '0;
            lcr_q <= '0;
            efr_q <= '0;
        end else if (we) begin
            case (addr)
                AW'(A_FCR): begin
                    for (int b = 0; b < DW; b++) begin
                        if (b != FCR_EXT_BIT || lcr_q[LCR_GRD_BIT])
                            fcr_q[b] <= wdata[b];
                    end
                end
                AW'(A_LCR): lcr_q <= wdata;
                AW'(A_EFR): efr_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            AW'(A_LCR): rdata = lcr_q;
            AW'(A_EFR): rdata = efr_q;
            default:    rdata = '0;
        endcase
    end

    assign bits.enable = fcr_q[FCR_EN_BIT];
    assign bits.ext    = fcr_q[FCR_EXT_BIT];
    assign bits.guard  = lcr_q[LCR_GRD_BIT];
    assign bits.enh    = efr_q[EFR_ENH_BIT];

    // R5: unguarded writes leave the extension bit alone
    a_r5_guarded_ext: assert property (@(posedge clk) disable iff (rst)
        (we && addr == AW'(A_FCR) && !bits.guard) |=> $stable(bits.ext));

    // R5: the enable bit follows every FIFO control write
    a_r5_enable_written: assert property (@(posedge clk) disable iff (rst)
        (we && addr == AW'(A_FCR)) |=> (bits.enable == $past(wdata[FCR_EN_BIT])));

endmodule

// File: rtl/chanfifo_decode.sv
module chanfifo_decode
    import chanfifo_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  mode_bits_t       bits,
    input  logic             deep_sel_n,
    output fifo_mode_e       mode,
    output logic [CW-1:0]    depth
);

    always_comb begin
        if (!bits.enable)
            mode = MODE_BYTE;
        else if (bits.enh)
            mode = MODE_ENH;
        else if (!deep_sel_n)
            mode = MODE_PIN;
        else if (bits.ext)
            mode = MODE_EXT;
        else
            mode = MODE_D16;
    end

    assign depth = CW'(depth_of(mode));

endmodule

// File: rtl/chanfifo_store.sv
module chanfifo_store
    import chanfifo_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = STORE_DEPTH,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] limit,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          full,
    output logic          empty,
    output logic          overflow,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cnt, limit_q;
    logic          flush, push_ok, pop_ok;

    assign flush   = (limit != limit_q);
    assign full    = (cnt == limit_q);
    assign empty   = (cnt == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            cnt      <= '0;
            limit_q  <= CW'(1);
            overflow <= 1'b0;
        end else begin
            limit_q  <= limit;
            overflow <= push && full && !flush;
            if (flush) begin
                wptr <= '0;
                rptr <= '0;
                cnt  <= '0;
            end else begin
                if (push_ok) wptr <= wptr + PW'(1);
                if (pop_ok)  rptr <= rptr + PW'(1);
                case ({push_ok, pop_ok})
                    2'b10:   cnt <= cnt + CW'(1);
                    2'b01:   cnt <= cnt - CW'(1);
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    assign pop_data = mem[rptr];
    assign count    = cnt;

    // R8: a refused push raises the overflow pulse next cycle
    a_r8_drop_flagged: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush) |=> overflow);

    // R8: occupancy never exceeds the depth in force
    a_r8_within_limit: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit_q);

    // R10: a depth change leaves the queue empty
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0));

    // R8: popping an empty queue with no push keeps it empty
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> empty);

endmodule

// File: rtl/chanfifo_ctrl.sv
module chanfifo_ctrl
    import chanfifo_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int DEPTH = STORE_DEPTH,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          deep_sel_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          full,
    output logic          empty,
    output logic          overflow,
    output logic [CW-1:0] count,
    output logic [2:0]    mode,
    output logic [CW-1:0] depth
);

    mode_bits_t bits;
    fifo_mode_e mode_e;

    chanfifo_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .bits  (bits)
    );

    chanfifo_decode #(.CW(CW)) u_decode (
        .bits       (bits),
        .deep_sel_n (deep_sel_n),
        .mode       (mode_e),
        .depth      (depth)
    );

    chanfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .limit     (depth),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .full      (full),
        .empty     (empty),
        .overflow  (overflow),
        .count     (count)
    );

    assign mode = mode_e;

    // R2: with the enable bit clear the mode stays byte
    a_r2_byte_gate: assert property (@(posedge clk) disable iff (rst)
        (!bits.enable) |-> (mode == 3'd0 && depth == CW'(1)));

endmodule

// File: tb/chanfifo_ctrl_test.sv
module chanfifo_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       deep_sel_n = 1'b1;
    logic       push = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       full, empty, overflow;
    logic [7:0] count;
    logic [2:0] mode;
    logic [7:0] depth;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chanfifo_ctrl uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .deep_sel_n(deep_sel_n),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .full(full), .empty(empty), .overflow(overflow), .count(count),
        .mode(mode), .depth(depth)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
        tick();
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_pin(input logic v);
        deep_sel_n = v;
        tick();
        tick();
    endtask

    task automatic push1(input logic [7:0] d);
        push = 1'b1; push_data = d;
        tick();
        push = 1'b0;
    endtask

    task automatic pop1(output logic [7:0] d);
        d = pop_data;
        pop = 1'b1;
        tick();
        pop = 1'b0;
    endtask

    task automatic drain();
        while (!empty) begin
            logic [7:0] d;
            pop1(d);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk_eq("R1 mode", mode, 0);
        chk_eq("R1 depth", depth, 1);
        chk_eq("R1 empty", empty, 1);
        chk_eq("R1 full", full, 0);
        reg_rd(2'd1, d); chk_eq("R1 line ctrl", d, 0);
        reg_rd(2'd2, d); chk_eq("R1 enh reg", d, 0);
    endtask

    task automatic t_byte();
        logic [7:0] d;
        reg_wr(2'd2, 8'h10);
        set_pin(1'b0);
        chk_eq("R2 mode pin low enh", mode, 0);
        chk_eq("R2 depth pin low enh", depth, 1);
        reg_wr(2'd2, 8'h00);
        set_pin(1'b1);
        push1(8'h5A);
        chk_eq("R2 full after one", full, 1);
        chk_eq("R2 count one", count, 1);
        push1(8'hB7);
        chk_eq("R8 overflow pulse", overflow, 1);
        chk_eq("R8 count after drop", count, 1);
        tick();
        chk_eq("R8 overflow ends", overflow, 0);
        pop1(d);
        chk_eq("R9 byte data", d, 8'h5A);
        chk_eq("R8 empty after pop", empty, 1);
        pop1(d);
        chk_eq("R8 pop on empty", count, 0);
    endtask

    task automatic t_guard();
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd0, 8'h21);
        chk_eq("R5 ext blocked", mode, 1);
        chk_eq("R3 depth 16", depth, 16);
        reg_wr(2'd1, 8'h80);
        reg_wr(2'd0, 8'h21);
        reg_wr(2'd1, 8'h00);
        chk_eq("R6 mode ext", mode, 3);
        chk_eq("R6 depth ext", depth, 128);
        reg_wr(2'd0, 8'h01);
        chk_eq("R5 ext kept", mode, 3);
        reg_wr(2'd0, 8'h20);
        chk_eq("R5 enable cleared unguarded", mode, 0);
        reg_wr(2'd0, 8'h01);
        chk_eq("R5 ext survives", mode, 3);
        reg_wr(2'd1, 8'h80);
        reg_wr(2'd0, 8'h01);
        reg_wr(2'd1, 8'h00);
        chk_eq("R5 ext cleared guarded", mode, 1);
    endtask

    task automatic t_depth16();
        logic [7:0] d;
        for (int i = 0; i < 16; i++) begin
            push1(8'h30 + 8'(i));
            if (i == 14) chk_eq("R8 not full at 15", full, 0);
        end
        chk_eq("R8 full at 16", full, 1);
        chk_eq("R3 count 16", count, 16);
        push1(8'hFF);
        chk_eq("R8 overflow 16", overflow, 1);
        for (int i = 0; i < 16; i++) begin
            pop1(d);
            chk_eq("R9 order 16", d, 8'h30 + i);
        end
        chk_eq("R9 empty after drain", empty, 1);
    endtask

    task automatic t_simul();
        logic [7:0] d;
        push1(8'hA0); push1(8'hA1); push1(8'hA2);
        d = pop_data;
        push = 1'b1; push_data = 8'hA3; pop = 1'b1;
        tick();
        push = 1'b0; pop = 1'b0;
        chk_eq("R9 simul data", d, 8'hA0);
        chk_eq("R9 simul count", count, 3);
        for (int i = 0; i < 13; i++) push1(8'hC0 + 8'(i));
        chk_eq("R8 full before simul", full, 1);
        d = pop_data;
        push = 1'b1; push_data = 8'hEE; pop = 1'b1;
        tick();
        push = 1'b0; pop = 1'b0;
        chk_eq("R8 full simul data", d, 8'hA1);
        chk_eq("R8 full simul count", count, 15);
        chk_eq("R8 full simul overflow", overflow, 1);
        drain();
        push = 1'b1; push_data = 8'h77; pop = 1'b1;
        tick();
        push = 1'b0; pop = 1'b0;
        chk_eq("R9 empty simul count", count, 1);
        chk_eq("R9 empty simul data", pop_data, 8'h77);
        drain();
    endtask

    task automatic t_flush();
        for (int i = 0; i < 5; i++) push1(8'(i));
        chk_eq("R10 pre count", count, 5);
        set_pin(1'b0);
        chk_eq("R4 mode pin", mode, 2);
        chk_eq("R4 depth pin", depth, 128);
        chk_eq("R10 flushed", count, 0);
        chk_eq("R10 empty", empty, 1);
        for (int i = 0; i < 128; i++) push1(8'(i));
        chk_eq("R4 full 128", full, 1);
        chk_eq("R4 count 128", count, 128);
        push1(8'hAA);
        chk_eq("R8 overflow 128", overflow, 1);
        chk_eq("R9 head 128", pop_data, 0);
        deep_sel_n = 1'b1;
        push = 1'b1; push_data = 8'h11;
        tick();
        push = 1'b0;
        chk_eq("R10 push discarded", count, 0);
        tick();
        chk_eq("R3 back to 16", depth, 16);
        chk_eq("R10 still empty", count, 0);
    endtask

    task automatic t_enh();
        reg_wr(2'd2, 8'h10);
        chk_eq("R7 mode enh", mode, 4);
        chk_eq("R7 depth enh", depth, 128);
        set_pin(1'b0);
        chk_eq("R7 pin low", mode, 4);
        reg_wr(2'd1, 8'h80);
        reg_wr(2'd0, 8'h21);
        reg_wr(2'd1, 8'h00);
        chk_eq("R7 ext set", mode, 4);
        reg_wr(2'd0, 8'h00);
        chk_eq("R2 enh without enable", mode, 0);
        chk_eq("R2 enh depth", depth, 1);
        reg_wr(2'd2, 8'h00);
        set_pin(1'b1);
    endtask

    task automatic t_read();
        logic [7:0] d;
        reg_wr(2'd1, 8'h5A);
        reg_wr(2'd2, 8'hC3);
        reg_rd(2'd1, d); chk_eq("R11 line ctrl", d, 8'h5A);
        reg_rd(2'd2, d); chk_eq("R11 enh reg", d, 8'hC3);
        reg_rd(2'd0, d); chk_eq("R11 fifo ctrl reads 0", d, 0);
        reg_rd(2'd3, d); chk_eq("R11 spare reads 0", d, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_byte();
        t_guard();
        t_depth16();
        t_simul();
        t_flush();
        t_enh();
        t_read();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule